// File: doc/BRIEF.md
# Overlapped-Translation Two-Way Data Cache Read Path

This block is the read side of a small data cache that starts its set lookup before address translation has finished. The set index and the byte position inside a line are taken only from the low twelve address bits, which are identical in the virtual and the physical address. The array read can therefore begin in the same cycle that the page number goes to the translation buffer. One cycle later the translation buffer returns a physical tag and a hit flag. The two stored physical tags of the selected set are compared against that tag, and the matching way supplies the requested 32-bit word.

Each of the 64 sets holds two ways, and each way holds one 64-byte line. A stored line can only live in the set named by its untranslated bits, so two virtual aliases of one physical line always land in the same set. Lines enter through a fill port that names the set, the physical tag and the full line. The block chooses the way itself. It prefers a way that already holds that tag, then an empty way with way 0 first, then the least recently used way. One recency bit per set is updated on every hit and on every fill.

Top module: `vipt_cache`

## Requirements
- R1: After reset, `resp_valid` and `resp_hit` are 0 and every way of every set is empty, so any lookup misses until a line has been filled.
- R2: A request presented with `req_valid` high at clock edge k produces its response (`resp_valid`=1, `resp_hit`, `resp_data`) right after edge k+1. The translation inputs `tlb_hit` and `tlb_ptag` are sampled at edge k+1. Requests may be issued on consecutive cycles, and their responses follow on consecutive cycles.
- R3: `resp_hit` is 1 only if `tlb_hit` was 1 for that request. When `resp_hit` is 0, `resp_data` is 0.
- R4: With `tlb_hit`=1, a lookup misses unless a valid way of the indexed set holds exactly `tlb_ptag` (20 bits, physical address bits 31..12).
- R5: On a hit, `resp_data` is word `req_offset[5:2]` of the matching line, where word n occupies `fill_line[32n+31:32n]`. `req_offset[1:0]` has no effect.
- R6: The set index is `req_offset[11:6]`. A line filled into set s is never seen by a lookup into a different set, even when the tag is the same.
- R7: A fill into a set that holds no copy of the tag writes the first empty way, way 0 before way 1. Two fills with different tags into one set both remain resident.
- R8: When both ways are valid, a fill of a new tag replaces the least recently used way. A hit makes its own way the most recently used.
- R9: A fill also makes its way the most recently used. After two fills into an empty set, a third fill of a new tag evicts the first one.
- R10: A fill whose tag is already resident in the set overwrites that same way. The other way is kept, and at most one way ever matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all valid and recency bits |
| req_valid | input | 1 | Start a lookup this cycle |
| req_offset | input | 12 | Untranslated address bits: [11:6] set, [5:2] word, [1:0] byte |
| tlb_hit | input | 1 | Translation succeeded (second cycle of the lookup) |
| tlb_ptag | input | 20 | Translated physical page number (second cycle) |
| fill_valid | input | 1 | Write a line this cycle |
| fill_set | input | 6 | Set that receives the line |
| fill_ptag | input | 20 | Physical tag of the line |
| fill_line | input | 512 | Line data, word n in bits 32n+31..32n |
| resp_valid | output | 1 | A response is present |
| resp_hit | output | 1 | The lookup hit |
| resp_data | output | 32 | Selected word on a hit, zero otherwise |

## Verification
A lookup occupies two registered stages. The set read is captured at the first edge after `req_valid`. The compare result and the word are captured at the next edge, together with the translation inputs. The bench drives inputs on falling edges, places the translation inputs in the cycle after the request, and samples the response on the second falling edge after the request. Two further checks confirm that nothing is reported one cycle early and that back-to-back requests return on consecutive cycles. A fill takes effect at the edge that captures it, and the bench issues lookups to that set only after that edge, so recency and replacement are observed through later hits and misses.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  localparam int DEF_PADDR_W    = 32;
  localparam int DEF_PAGE_BITS  = 12;
  localparam int DEF_LINE_BYTES = 64;
  localparam int DEF_WORD_BYTES = 4;
  localparam int NUM_WAYS       = 2;

  typedef logic way_t;

  // Replacement choice for a two-way set: a way already holding the tag,
  // else the first empty way, else the least recently used one.
  function automatic way_t pick_victim(input logic [1:0] vld,
                                       input logic [1:0] match,
                                       input way_t       lru_way);
    if (match[0])      return 1'b0;
    else if (match[1]) return 1'b1;
    else if (!vld[0])  return 1'b0;
    else if (!vld[1])  return 1'b1;
    else               return lru_way;
  endfunction

endpackage

// File: rtl/vipt_tag_array.sv
module vipt_tag_array #(
  parameter int SETS  = 64,
  parameter int TAG_W = 20,
  parameter int WAYS  = 2,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0]             rd_vld,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_set,
  input  logic                        wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  output logic [WAYS-1:0]             wr_set_vld,
  output logic [WAYS-1:0]             wr_set_match
);

  logic [TAG_W-1:0] tag_mem [WAYS][SETS];
  logic [SETS-1:0]  vld_mem [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == w[0])) tag_mem[w][wr_set] <= wr_tag;
      if (rd_en) rd_tag[w] <= tag_mem[w][rd_set];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_mem[w] <= '0;
        rd_vld[w]  <= 1'b0;
      end else begin
        if (wr_en && (wr_way == w[0])) vld_mem[w][wr_set] <= 1'b1;
        if (rd_en) rd_vld[w] <= vld_mem[w][rd_set];
      end
    end

    // Occupancy of the fill target set, used for the way choice.
    assign wr_set_vld[w]   = vld_mem[w][wr_set];
    assign wr_set_match[w] = vld_mem[w][wr_set] && (tag_mem[w][wr_set] == wr_tag);
  end

  assert_fill_marks_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_mem[$past(wr_way)][$past(wr_set)]);

  assert_single_resident_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot0(wr_set_match));

endmodule

// File: rtl/vipt_data_array.sv
module vipt_data_array #(
  parameter int SETS   = 64,
  parameter int LINE_W = 512,
  parameter int WAYS   = 2,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_set,
  output logic [WAYS-1:0][LINE_W-1:0] rd_line,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_set,
  input  logic                        wr_way,
  input  logic [LINE_W-1:0]           wr_line
);

  logic [LINE_W-1:0] line_mem [WAYS][SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == w[0])) line_mem[w][wr_set] <= wr_line;
      if (rd_en) rd_line[w] <= line_mem[w][rd_set];
    end
  end

endmodule

// File: rtl/vipt_lru.sv
module vipt_lru
  import vipt_pkg::*;
#(
  parameter int SETS = 64,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_set,
  input  way_t             hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [1:0]       fill_vld,
  input  logic [1:0]       fill_match,
  output way_t             victim
);

  // Bit set = way to evict next in that set.
  logic [SETS-1:0] lru_q;

  assign victim = pick_victim(fill_vld, fill_match, lru_q[fill_set]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else begin
      if (hit_en)  lru_q[hit_set]  <= ~hit_way;
      if (fill_en) lru_q[fill_set] <= ~victim;
    end
  end

  assert_hit_makes_mru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en && !(fill_en && fill_set == hit_set))
      |=> lru_q[$past(hit_set)] == ~$past(hit_way));

  assert_fill_makes_mru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> lru_q[$past(fill_set)] == ~$past(victim));

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int PADDR_W    = DEF_PADDR_W,
  parameter int PAGE_BITS  = DEF_PAGE_BITS,
  parameter int LINE_BYTES = DEF_LINE_BYTES,
  parameter int WORD_BYTES = DEF_WORD_BYTES,
  localparam int TAG_W  = PADDR_W - PAGE_BITS,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = PAGE_BITS - OFF_W,
  localparam int SETS   = 1 << IDX_W,
  localparam int WORD_W = 8 * WORD_BYTES,
  localparam int BYTE_W = $clog2(WORD_BYTES),
  localparam int WSEL_W = OFF_W - BYTE_W,
  localparam int LINE_W = 8 * LINE_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [PAGE_BITS-1:0] req_offset,
  input  logic                 tlb_hit,
  input  logic [TAG_W-1:0]     tlb_ptag,
  input  logic                 fill_valid,
  input  logic [IDX_W-1:0]     fill_set,
  input  logic [TAG_W-1:0]     fill_ptag,
  input  logic [LINE_W-1:0]    fill_line,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output logic [WORD_W-1:0]    resp_data
);

  localparam int WAYS = NUM_WAYS;

  function automatic logic [IDX_W-1:0] set_of(input logic [PAGE_BITS-1:0] off);
    return off[PAGE_BITS-1:OFF_W];
  endfunction

  function automatic logic [WSEL_W-1:0] word_of(input logic [PAGE_BITS-1:0] off);
    return off[OFF_W-1:BYTE_W];
  endfunction

  function automatic logic [WORD_W-1:0] slice_word(input logic [LINE_W-1:0] line,
                                                   input logic [WSEL_W-1:0] sel);
    return line[sel*WORD_W +: WORD_W];
  endfunction

  // Stage 1: set read from untranslated bits
  logic [IDX_W-1:0] req_set;
  logic             s2_valid;
  logic [IDX_W-1:0] s2_set;
  logic [WSEL_W-1:0] s2_word;

  assign req_set = set_of(req_offset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_set   <= '0;
      s2_word  <= '0;
    end else begin
      s2_valid <= req_valid;
      if (req_valid) begin
        s2_set  <= req_set;
        s2_word <= word_of(req_offset);
      end
    end
  end

  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0]             rd_vld;
  logic [WAYS-1:0][LINE_W-1:0] rd_line;
  logic [WAYS-1:0]             fill_vld;
  logic [WAYS-1:0]             fill_match;
  way_t                        fill_way;

  vipt_tag_array #(.SETS(SETS), .TAG_W(TAG_W), .WAYS(WAYS)) u_tags (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (req_valid),
    .rd_set       (req_set),
    .rd_tag       (rd_tag),
    .rd_vld       (rd_vld),
    .wr_en        (fill_valid),
    .wr_set       (fill_set),
    .wr_way       (fill_way),
    .wr_tag       (fill_ptag),
    .wr_set_vld   (fill_vld),
    .wr_set_match (fill_match)
  );

  vipt_data_array #(.SETS(SETS), .LINE_W(LINE_W), .WAYS(WAYS)) u_data (
    .clk     (clk),
    .rd_en   (req_valid),
    .rd_set  (req_set),
    .rd_line (rd_line),
    .wr_en   (fill_valid),
    .wr_set  (fill_set),
    .wr_way  (fill_way),
    .wr_line (fill_line)
  );

  // Stage 2: physical tag compare once translation is available
  logic [WAYS-1:0] way_match;
  logic            lookup_hit;
  way_t            hit_way;
  logic [WORD_W-1:0] hit_word;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_match[w] = rd_vld[w] && (rd_tag[w] == tlb_ptag);
  end

  assign lookup_hit = s2_valid && tlb_hit && (|way_match);
  assign hit_way    = way_match[1];
  assign hit_word   = slice_word(rd_line[hit_way], s2_word);

  vipt_lru #(.SETS(SETS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_en     (lookup_hit),
    .hit_set    (s2_set),
    .hit_way    (hit_way),
    .fill_en    (fill_valid),
    .fill_set   (fill_set),
    .fill_vld   (fill_vld),
    .fill_match (fill_match),
    .victim     (fill_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= s2_valid;
      resp_hit   <= lookup_hit;
      resp_data  <= lookup_hit ? hit_word : '0;
    end
  end

  assert_resp_two_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid, 2));

  assert_hit_needs_translation_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> ($past(tlb_hit) && resp_valid));

  assert_one_way_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> $onehot0(way_match));

endmodule

// File: tb/vipt_cache_test.sv
module vipt_cache_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [11:0]  req_offset = '0;
  logic         tlb_hit = 1'b0;
  logic [19:0]  tlb_ptag = '0;
  logic         fill_valid = 1'b0;
  logic [5:0]   fill_set = '0;
  logic [19:0]  fill_ptag = '0;
  logic [511:0] fill_line = '0;
  logic         resp_valid;
  logic         resp_hit;
  logic [31:0]  resp_data;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  vipt_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
    .tlb_hit(tlb_hit), .tlb_ptag(tlb_ptag), .fill_valid(fill_valid),
    .fill_set(fill_set), .fill_ptag(fill_ptag), .fill_line(fill_line),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data)
  );

  // Expected word content, built independently of the design.
  function automatic logic [31:0] pat(input logic [19:0] tag, input logic [5:0] set,
                                      input logic [3:0] w, input logic alt);
    return {tag[15:0], (alt ? 4'hA : 4'h0), set, 2'b01, w};
  endfunction

  function automatic logic [511:0] mk_line(input logic [19:0] tag, input logic [5:0] set,
                                           input logic alt);
    logic [511:0] l;
    for (int w = 0; w < 16; w++) l[32*w +: 32] = pat(tag, set, w[3:0], alt);
    return l;
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_fill(input logic [5:0] set, input logic [19:0] tag, input logic alt);
    @(negedge clk);
    fill_valid = 1'b1; fill_set = set; fill_ptag = tag; fill_line = mk_line(tag, set, alt);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic lookup(input logic [11:0] off, input logic tlb, input logic [19:0] tag,
                        output logic hit, output logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0; tlb_hit = tlb; tlb_ptag = tag;
    @(negedge clk);
    hit = resp_hit; data = resp_data;
    tlb_hit = 1'b0;
  endtask

  task automatic expect_lookup(input string rq, input logic [5:0] set, input logic [3:0] w,
                               input logic [19:0] tag, input logic exp_hit, input logic alt);
    logic h; logic [31:0] d;
    lookup({set, w, 2'b00}, 1'b1, tag, h, d);
    check(rq, {31'd0, h}, {31'd0, exp_hit});
    check(rq, d, exp_hit ? pat(tag, set, w, alt) : 32'd0);
  endtask

  // Vector: {set[5:0], word[3:0], tlb, tag[19:0], expected hit}
  localparam logic [31:0] VEC [10] = '{
    {6'd3,  4'd0,  1'b1, 20'h12345, 1'b1},  // R5 word 0
    {6'd3,  4'd15, 1'b1, 20'h0ABCD, 1'b1},  // R5 last word, other way
    {6'd3,  4'd7,  1'b0, 20'h12345, 1'b0},  // R3 translation miss
    {6'd3,  4'd7,  1'b1, 20'h12346, 1'b0},  // R4 tag off by one
    {6'd40, 4'd9,  1'b1, 20'h12345, 1'b1},  // R6 same tag own set
    {6'd41, 4'd9,  1'b1, 20'h12345, 1'b0},  // R6 neighbour set
    {6'd63, 4'd15, 1'b1, 20'hFFFFF, 1'b1},  // R5 top set
    {6'd0,  4'd0,  1'b1, 20'h00001, 1'b1},  // R5 set 0
    {6'd0,  4'd1,  1'b1, 20'h0ABCD, 1'b0},  // R4 tag of another set
    {6'd40, 4'd2,  1'b0, 20'h12345, 1'b0}   // R3 translation miss on resident line
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    logic h; logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 resp_valid in reset", {31'd0, resp_valid}, 32'd0);
    check("R1 resp_hit in reset",   {31'd0, resp_hit},   32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    lookup({6'd5, 4'd0, 2'b00}, 1'b1, 20'h00000, h, d);
    check("R1 empty cache misses", {31'd0, h}, 32'd0);
    check("R1 miss data zero", d, 32'd0);

    do_fill(6'd3,  20'h12345, 1'b0);
    do_fill(6'd3,  20'h0ABCD, 1'b0);
    do_fill(6'd40, 20'h12345, 1'b0);
    do_fill(6'd63, 20'hFFFFF, 1'b0);
    do_fill(6'd0,  20'h00001, 1'b0);

    for (int i = 0; i < 10; i++) begin
      logic [5:0] s; logic [3:0] w; logic t; logic [19:0] tg; logic eh;
      {s, w, t, tg, eh} = VEC[i];
      // R5: byte bits vary and must not matter
      lookup({s, w, i[1:0]}, t, tg, h, d);
      check($sformatf("vector %0d hit (R3/R4/R5/R6)", i), {31'd0, h}, {31'd0, eh});
      check($sformatf("vector %0d data (R3/R5)", i), d, eh ? pat(tg, s, w, 1'b0) : 32'd0);
    end

    // R2: timing and back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_offset = {6'd3, 4'd4, 2'b00};
    @(negedge clk);
    check("R2 no response after one edge", {31'd0, resp_valid}, 32'd0);
    req_offset = {6'd40, 4'd6, 2'b00};
    tlb_hit = 1'b1; tlb_ptag = 20'h12345;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 first response valid", {31'd0, resp_valid}, 32'd1);
    check("R2 first response data", resp_data, pat(20'h12345, 6'd3, 4'd4, 1'b0));
    tlb_ptag = 20'h12345;
    @(negedge clk);
    tlb_hit = 1'b0;
    check("R2 second response valid", {31'd0, resp_valid}, 32'd1);
    check("R2 second response data", resp_data, pat(20'h12345, 6'd40, 4'd6, 1'b0));
    @(negedge clk);
    check("R2 no response without request", {31'd0, resp_valid}, 32'd0);

    // R7: two tags into an empty set both stay
    do_fill(6'd10, 20'h00A0A, 1'b0);
    do_fill(6'd10, 20'h00B0B, 1'b0);
    expect_lookup("R7 first tag resident",  6'd10, 4'd3, 20'h00A0A, 1'b1, 1'b0);
    expect_lookup("R7 second tag resident", 6'd10, 4'd8, 20'h00B0B, 1'b1, 1'b0);

    // R10: refill of a resident tag overwrites it, keeps the other way
    do_fill(6'd10, 20'h00A0A, 1'b1);
    expect_lookup("R10 refilled data", 6'd10, 4'd5, 20'h00A0A, 1'b1, 1'b1);
    expect_lookup("R10 other way kept", 6'd10, 4'd5, 20'h00B0B, 1'b1, 1'b0);

    // R8: a hit protects its way from eviction
    do_fill(6'd20, 20'h0A000, 1'b0);
    do_fill(6'd20, 20'h0B000, 1'b0);
    expect_lookup("R8 touch first tag", 6'd20, 4'd1, 20'h0A000, 1'b1, 1'b0);
    do_fill(6'd20, 20'h0C000, 1'b0);
    expect_lookup("R8 touched tag kept", 6'd20, 4'd2, 20'h0A000, 1'b1, 1'b0);
    expect_lookup("R8 lru tag evicted",  6'd20, 4'd2, 20'h0B000, 1'b0, 1'b0);
    expect_lookup("R8 new tag resident", 6'd20, 4'd2, 20'h0C000, 1'b1, 1'b0);

    // R9: fills alone set recency
    do_fill(6'd30, 20'h1A000, 1'b0);
    do_fill(6'd30, 20'h1B000, 1'b0);
    do_fill(6'd30, 20'h1C000, 1'b0);
    expect_lookup("R9 oldest fill evicted", 6'd30, 4'd0, 20'h1A000, 1'b0, 1'b0);
    expect_lookup("R9 second fill kept",    6'd30, 4'd0, 20'h1B000, 1'b1, 1'b0);
    expect_lookup("R9 third fill resident", 6'd30, 4'd0, 20'h1C000, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule